// File: doc/BRIEF.md
# Microsecond Event Timer (One-Shot and Periodic)

This block is a down-counting event timer that advances only on a one-microsecond strobe supplied from outside. Software programs it with a single write to its load word, which carries a run flag, a repeat flag and a count of ticks minus one. When the countdown passes zero the block raises a level-high interrupt. In one-shot use it then halts; in repeat use it reloads the programmed count and carries on, so that a count of 9999 gives a 100 Hz interrupt. Software clears the interrupt by writing a one to the acknowledge bit of a separate status word. Reading the status word returns the ticks that remain.

The control core is a three-state machine. The states are `ST_IDLE` (no countdown), `ST_ONCE` (counting, halts at expiry) and `ST_REPEAT` (counting, reloads at expiry). A load-word write moves any state to `ST_IDLE` when the run flag is clear. With the run flag set, it moves to `ST_ONCE` if the repeat flag is clear, or to `ST_REPEAT` if the repeat flag is set. `ST_ONCE` moves to `ST_IDLE` on a tick that finds the count at zero. `ST_REPEAT` stays in `ST_REPEAT` on that event and reloads. A load-word write takes priority over every other transition in the same cycle.

Top module: `usec_event_timer`

## Requirements
- R1: After reset the state is idle, the remaining count and the stored load word are zero, `irq` is low, and both read selections return zero.
- R2: A write with `wr_sel`=0 (load word) takes bit 31 as the run flag, bit 30 as the repeat flag and bits [28:0] as the count. The written count becomes the remaining count at once, and any countdown in progress is abandoned. Reading with `rd_sel`=0 returns bit 31 = running, bit 30 = repeat flag, bits [28:0] = stored count, and zeros elsewhere.
- R3: With a count of V written, the expiry happens on the (V+1)-th tick after the write. Each tick before it lowers the count by one, and cycles without `tick_us` leave the count unchanged.
- R4: Reading with `rd_sel`=1 (status word) returns the remaining count in bits [28:0] and zeros elsewhere.
- R5: In one-shot mode, expiry sets `irq`, clears the running flag and leaves the count at zero. Further ticks raise no new event.
- R6: In repeat mode, expiry sets `irq` and reloads the stored count, and counting continues, so events recur every V+1 ticks.
- R7: A load-word write with bit 31 clear stops the timer. The remaining count takes the written count field and no tick changes it, nor raises an event.
- R8: `irq` is active high and stays set until a status-word write (`wr_sel`=1) with bit 30 set. A status write with bit 30 clear, or a load-word write, leaves it set.
- R9: When an acknowledge and an expiry fall in the same cycle, `irq` remains set.
- R10: The largest count, 0x1FFFFFFF, is accepted and counts down normally.
- R11: When a load-word write and a tick fall in the same cycle, the written count is taken and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 load word, 1 status word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 load word, 1 status word |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level-high event interrupt |

## Verification
The hardest situations to reach are the coincidences: an acknowledge landing in the exact cycle of a repeat-mode expiry, and a reprogramming write landing on a tick. The stimulus reaches them by counting ticks from a known load. It drives the repeat timer down to zero with single-tick steps, then applies the final tick together with the acknowledge or write in one cycle. A maximum-count load is checked by reading back the count after a few ticks rather than waiting for expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ONCE   = 2'd1,
        ST_REPEAT = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 29
) (
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              load_wr,
    output logic              load_run,
    output logic              load_rep,
    output logic [CNT_W-1:0]  load_cnt,
    output logic              ack_wr
);
    localparam int RUN_BIT = DATA_W - 1;
    localparam int REP_BIT = DATA_W - 2;
    localparam int ACK_BIT = DATA_W - 2;
    localparam int GAP_W   = DATA_W - 2 - CNT_W;

    logic unused_gap;

    always_comb begin
        load_wr  = wr_en && !wr_sel;
        load_run = wr_data[RUN_BIT];
        load_rep = wr_data[REP_BIT];
        load_cnt = wr_data[CNT_W-1:0];
        ack_wr   = wr_en && wr_sel && wr_data[ACK_BIT];
    end

    assign unused_gap = ^wr_data[CNT_W +: GAP_W];

endmodule

// File: rtl/tmr_fsm.sv
module tmr_fsm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic             load_run,
    input  logic             load_rep,
    input  logic [CNT_W-1:0] load_cnt,
    output tmr_state_e       state_q,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             rep_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    tmr_state_e state_d;
    logic       at_zero;

    assign at_zero = (count_q == CNT_ZERO);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (load_wr) begin
            if (!load_run)     state_d = ST_IDLE;
            else if (load_rep) state_d = ST_REPEAT;
            else               state_d = ST_ONCE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_ONCE:   if (tick && at_zero) state_d = ST_IDLE;
                ST_REPEAT: state_d = ST_REPEAT;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // counter and stored load word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            rep_q    <= 1'b0;
        end else if (load_wr) begin
            count_q  <= load_cnt;
            reload_q <= load_cnt;
            rep_q    <= load_rep;
        end else if (tick && state_q != ST_IDLE) begin
            if (!at_zero)                   count_q <= count_q - CNT_ONE;
            else if (state_q == ST_REPEAT)  count_q <= reload_q;
        end
    end

    // outputs
    always_comb begin
        expire = tick && !load_wr && (state_q != ST_IDLE) && at_zero;
    end

    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && tick && !load_wr && count_q != CNT_ZERO)
        |=> (count_q == $past(count_q) - CNT_ONE));

    assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_wr) |=> $stable(count_q));

    assert_oneshot_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONCE && expire) |=> (state_q == ST_IDLE && count_q == CNT_ZERO));

    assert_repeat_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPEAT && expire) |=> (state_q == ST_REPEAT && count_q == $past(reload_q)));

    assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load_wr) |=> ($stable(count_q) && state_q == ST_IDLE));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (count_q == $past(load_cnt)));

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      irq <= 1'b0;
        else if (expire) irq <= 1'b1;
        else if (ack)    irq <= 1'b0;
    end

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire) |=> !irq);

    assert_set_beats_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

endmodule

// File: rtl/usec_event_timer.sv
module usec_event_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int RUN_BIT = DATA_W - 1;
    localparam int REP_BIT = DATA_W - 2;

    logic             load_wr, load_run, load_rep, ack_wr, expire, rep_q;
    logic [CNT_W-1:0] load_cnt, count_q, reload_q;
    tmr_state_e       state_q;

    tmr_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_decode (
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .load_wr  (load_wr),
        .load_run (load_run),
        .load_rep (load_rep),
        .load_cnt (load_cnt),
        .ack_wr   (ack_wr)
    );

    tmr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .load_wr  (load_wr),
        .load_run (load_run),
        .load_rep (load_rep),
        .load_cnt (load_cnt),
        .state_q  (state_q),
        .count_q  (count_q),
        .reload_q (reload_q),
        .rep_q    (rep_q),
        .expire   (expire)
    );

    tmr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .ack    (ack_wr),
        .irq    (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[CNT_W-1:0] = count_q;
        end else begin
            rd_data[RUN_BIT]    = (state_q != ST_IDLE);
            rd_data[REP_BIT]    = rep_q;
            rd_data[CNT_W-1:0]  = reload_q;
        end
    end

    assert_reset_clean_R1: assert property (@(posedge clk)
        !rst_n |=> (rst_n || (!irq && count_q == '0)));

    assert_irq_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire));

endmodule

// File: tb/test_usec_event_timer.sv
module test_usec_event_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        bit          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    usec_event_timer i_usec_event_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_us (tick_us),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            item_t it;
            logic [31:0] got;
            wait (sb_q.size() > 0);
            #1;
            it = sb_q[0];
            rd_sel = it.sel;
            #1;
            got = it.is_irq ? {31'd0, irq} : rd_data;
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic expect_rd(input bit sel, input logic [31:0] exp, input string req);
        item_t it;
        it.is_irq = 1'b0; it.sel = sel; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic expect_irq(input bit lvl, input string req);
        item_t it;
        it.is_irq = 1'b1; it.sel = 1'b0; it.exp = {31'd0, lvl}; it.req = req;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // all drive tasks start and end just after a falling edge
    task automatic cycle(input bit tk, input bit we, input bit ws, input logic [31:0] d);
        tick_us = tk; wr_en = we; wr_sel = ws; wr_data = d;
        @(negedge clk);
        tick_us = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_rd(1'b0, 32'h0, "R1 load word after reset");
        expect_rd(1'b1, 32'h0, "R1 status word after reset");
        expect_irq(1'b0, "R1 irq after reset");

        // one-shot, count 4 -> fires on 5th tick
        cycle(1'b0, 1'b1, 1'b0, 32'h8000_0004);
        expect_rd(1'b0, 32'h8000_0004, "R2 load word readback");
        expect_rd(1'b1, 32'd4, "R4 status word after load");
        ticks(2);
        expect_rd(1'b1, 32'd2, "R3 count after two ticks");
        idle(3);
        expect_rd(1'b1, 32'd2, "R3 count held without ticks");
        ticks(2);
        expect_rd(1'b1, 32'd0, "R3 count at zero");
        expect_irq(1'b0, "R3 no event before final tick");
        ticks(1);
        expect_irq(1'b1, "R5 one-shot expiry sets irq");
        expect_rd(1'b0, 32'h0000_0004, "R5 run flag cleared");
        ticks(3);
        expect_rd(1'b1, 32'd0, "R5 count stays zero");
        expect_irq(1'b1, "R8 irq level held");

        // acknowledge
        cycle(1'b0, 1'b1, 1'b1, 32'h0000_0000);
        expect_irq(1'b1, "R8 status write without ack bit");
        cycle(1'b0, 1'b1, 1'b1, 32'h4000_0000);
        expect_irq(1'b0, "R8 ack clears irq");
        ticks(4);
        expect_irq(1'b0, "R5 no event after one-shot halt");

        // repeat mode, count 2
        cycle(1'b0, 1'b1, 1'b0, 32'hC000_0002);
        expect_rd(1'b0, 32'hC000_0002, "R2 repeat load readback");
        ticks(3);
        expect_irq(1'b1, "R6 first periodic event");
        expect_rd(1'b1, 32'd2, "R6 count reloaded");
        cycle(1'b0, 1'b1, 1'b1, 32'h4000_0000);
        expect_irq(1'b0, "R8 ack in repeat mode");
        ticks(3);
        expect_irq(1'b1, "R6 second periodic event");

        // R9 ack and expiry together
        cycle(1'b0, 1'b1, 1'b1, 32'h4000_0000);
        ticks(2);
        expect_rd(1'b1, 32'd0, "R9 setup count zero");
        expect_irq(1'b0, "R9 setup irq clear");
        cycle(1'b1, 1'b1, 1'b1, 32'h4000_0000);
        expect_irq(1'b1, "R9 expiry beats ack");
        expect_rd(1'b1, 32'd2, "R9 reload on coincident ack");

        // R7 stop with pending irq
        cycle(1'b0, 1'b1, 1'b0, 32'h0000_0007);
        expect_rd(1'b0, 32'h0000_0007, "R7 stopped load word");
        expect_irq(1'b1, "R8 load write keeps irq");
        cycle(1'b0, 1'b1, 1'b1, 32'h4000_0000);
        ticks(3);
        expect_rd(1'b1, 32'd7, "R7 count frozen when stopped");
        expect_irq(1'b0, "R7 no event when stopped");

        // R11 write and tick together
        cycle(1'b0, 1'b1, 1'b0, 32'h8000_000A);
        ticks(2);
        expect_rd(1'b1, 32'd8, "R11 setup countdown");
        cycle(1'b1, 1'b1, 1'b0, 32'h8000_0005);
        expect_rd(1'b1, 32'd5, "R11 write wins over tick");
        expect_rd(1'b0, 32'h8000_0005, "R2 reprogram abandons old count");

        // R10 maximum count
        cycle(1'b0, 1'b1, 1'b0, 32'h9FFF_FFFF);
        expect_rd(1'b0, 32'h9FFF_FFFF, "R10 max count readback");
        ticks(3);
        expect_rd(1'b1, 32'h1FFF_FFFC, "R10 max count decrements");
        expect_irq(1'b0, "R10 no early event");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule